// File: doc/BRIEF.md
# UART Buffer and Status Flags

This block sits between a processor's byte-wide write and read strobes and the serial shifters of a UART. Outgoing bytes are queued for a transmit shifter, which takes them with a pop strobe and reports while it is still sending a character. Incoming bytes arrive from a receive shifter as pushes and are read by the processor in arrival order. An active-low modem carrier-detect line is synchronised and reported.

A run-time mode input picks the buffer depth for both directions: a queue of `DEPTH` entries when set, a single holding register when clear. Any change of that input empties both buffers. The status word reports empty and full for each direction, a transmit-busy flag and carrier detect, and a separate sticky output records receive overrun.

Top module: `uart_buf_status`

## Requirements
- R1: After reset both buffers are empty, `flags_o` reads 8'h90 (bit 7 transmit-empty and bit 4 receive-empty set, all other bits 0), `rx_overrun_o` is 0 and `tx_valid_o` is 0.
- R2: `flags_o[2]` is the inverse of `cd_n_i` after a two-flop synchroniser: it takes a new level on the second rising edge after the input changes.
- R3: `flags_o[3]` (busy) is 1 whenever the transmit buffer holds a byte, whatever the level of `uart_en_i`.
- R4: Busy stays 1 while `tx_shifting_i` is 1 after the transmit buffer has emptied, and falls to 0 only once the buffer is empty and `tx_shifting_i` is 0.
- R5: With `fifo_en_i` at 0 the transmit side holds one byte: one write clears bit 7 and sets `flags_o[5]` (transmit-full); a further write is ignored.
- R6: With `fifo_en_i` at 1 the transmit side holds `DEPTH` bytes, sets bit 5 only when all are used, ignores writes while full, and hands bytes out oldest first.
- R7: Receive pushes clear bit 4; `flags_o[6]` (receive-full) is set at capacity (one entry in holding mode, `DEPTH` in queue mode); reads return bytes oldest first.
- R8: A push while the receive buffer is full is dropped and sets `rx_overrun_o`, which stays 1 until reset.
- R9: A read of an empty receive buffer returns 8'h00 and leaves it empty.
- R10: Any change of `fifo_en_i` empties both buffers on the next clock edge.
- R11: `tx_valid_o` is 1 only when the transmit buffer is non-empty and `uart_en_i` is 1; `tx_data_o` shows the oldest queued byte.
- R12: `flags_o[1:0]` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects queue depth, 0 selects a holding register |
| uart_en_i | input | 1 | UART enable; gates offering bytes to the shifter |
| cpu_wr_i | input | 1 | Processor write strobe into the transmit buffer |
| cpu_wdata_i | input | 8 | Byte written |
| cpu_rd_i | input | 1 | Processor read strobe from the receive buffer |
| cpu_rdata_o | output | 8 | Oldest received byte, 0 when empty |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit byte offered to the shifter |
| tx_pop_i | input | 1 | Shifter takes the offered byte |
| tx_shifting_i | input | 1 | Shifter is still sending a character |
| rx_push_i | input | 1 | Receive shifter delivers a byte |
| rx_data_i | input | 8 | Received byte |
| cd_n_i | input | 1 | Carrier detect, active low, asynchronous |
| flags_o | output | 8 | Status word |
| rx_overrun_o | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with `DEPTH` set to 4, so filling either queue, and writing or pushing past the limit, takes only a few strobes. The same build reaches both modes, since holding mode uses capacity one regardless of the parameter, and the flush on a mode change is exercised from a partly filled state in each direction.

// File: rtl/uart_buf_pkg.sv
// Package: bit positions of the status word, shared by the block and its users.
package uart_buf_pkg;
    localparam int FLAG_W       = 8;
    localparam int FB_CARRIER   = 2;
    localparam int FB_BUSY      = 3;
    localparam int FB_RX_EMPTY  = 4;
    localparam int FB_TX_FULL   = 5;
    localparam int FB_RX_FULL   = 6;
    localparam int FB_TX_EMPTY  = 7;
endpackage

// File: rtl/uart_cd_sync.sv
// Two-flop synchroniser for an asynchronous level.
// Assumes: the input is a slow level; reset value is the inactive level (1).
module uart_cd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic s1_q, s2_q;

    // Shift the level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/uart_byte_queue.sv
// Byte queue with run-time capacity: DEPTH entries when deep_i is 1,
// one entry otherwise. flush_i empties it and wins over push and pop.
// Assumes: DEPTH >= 2. Pushes when full and pops when empty are ignored.
module uart_byte_queue #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_i,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP_DEEP = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_ONE  = CW'(1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     count_q;
    logic [CW-1:0]     cap;
    logic              do_push, do_pop;

    // Capacity follows the mode input.
    assign cap     = deep_i ? CAP_DEEP : CAP_ONE;
    assign empty_o = (count_q == '0);
    assign full_o  = (count_q >= cap);
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;
    assign head_o  = empty_o ? '0 : mem_q[rd_ptr_q];

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R5/R6: occupancy never exceeds the selected capacity.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !$changed(deep_i)) |-> (count_q <= cap));

    // R9: popping an empty queue leaves it empty.
    a_r9_empty_pop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o);

    // R10: a flush leaves the queue empty.
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_q == '0));
endmodule

// File: rtl/uart_buf_status.sv
// Transmit and receive buffering for a UART with a status flag word.
// Assumes: one clock domain except cd_n_i, which is synchronised here.
// A change of fifo_en_i flushes both directions on the following edge.
module uart_buf_status #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en_i,
    input  logic       uart_en_i,
    input  logic       cpu_wr_i,
    input  logic [7:0] cpu_wdata_i,
    input  logic       cpu_rd_i,
    output logic [7:0] cpu_rdata_o,
    output logic [7:0] tx_data_o,
    output logic       tx_valid_o,
    input  logic       tx_pop_i,
    input  logic       tx_shifting_i,
    input  logic       rx_push_i,
    input  logic [7:0] rx_data_i,
    input  logic       cd_n_i,
    output logic [7:0] flags_o,
    output logic       rx_overrun_o
);
    import uart_buf_pkg::*;

    logic fifo_en_q, flush;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic cd_sync, busy, overrun_q;

    // Remember the mode to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_en_q <= 1'b0;
        else        fifo_en_q <= fifo_en_i;
    end
    assign flush = (fifo_en_i != fifo_en_q);

    uart_byte_queue #(.DEPTH(DEPTH), .DATA_W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .deep_i(fifo_en_i), .flush_i(flush),
        .push_i(cpu_wr_i), .push_data_i(cpu_wdata_i),
        .pop_i(tx_pop_i && uart_en_i), .head_o(tx_data_o),
        .empty_o(tx_empty), .full_o(tx_full)
    );

    uart_byte_queue #(.DEPTH(DEPTH), .DATA_W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .deep_i(fifo_en_i), .flush_i(flush),
        .push_i(rx_push_i), .push_data_i(rx_data_i),
        .pop_i(cpu_rd_i), .head_o(cpu_rdata_o),
        .empty_o(rx_empty), .full_o(rx_full)
    );

    uart_cd_sync u_cd (.clk(clk), .rst_n(rst_n), .async_i(cd_n_i), .sync_o(cd_sync));

    // Sticky record of dropped receive bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      overrun_q <= 1'b0;
        else if (rx_push_i && rx_full && !flush) overrun_q <= 1'b1;
    end

    assign busy         = !tx_empty || tx_shifting_i;
    assign tx_valid_o   = !tx_empty && uart_en_i;
    assign rx_overrun_o = overrun_q;

    // Assemble the status word.
    always_comb begin
        flags_o              = '0;
        flags_o[FB_CARRIER]  = !cd_sync;
        flags_o[FB_BUSY]     = busy;
        flags_o[FB_RX_EMPTY] = rx_empty;
        flags_o[FB_TX_FULL]  = tx_full;
        flags_o[FB_RX_FULL]  = rx_full;
        flags_o[FB_TX_EMPTY] = tx_empty;
    end

    // R3: an accepted write makes the block busy on the next cycle.
    a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && !tx_full && !flush) |=> flags_o[FB_BUSY]);

    // R8: overrun never clears once set.
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun_o |=> rx_overrun_o);

    // R10: a mode change leaves both directions empty.
    a_r10_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (flags_o[FB_TX_EMPTY] && flags_o[FB_RX_EMPTY]));

    // R12: the unused low bits stay clear.
    a_r12_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[1:0] == 2'b00);
endmodule

// File: tb/uart_buf_status_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_buf_status_tb;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en_i = 1'b0, uart_en_i = 1'b0;
    logic       cpu_wr_i = 1'b0, cpu_rd_i = 1'b0;
    logic [7:0] cpu_wdata_i = '0, rx_data_i = '0;
    logic       tx_pop_i = 1'b0, tx_shifting_i = 1'b0, rx_push_i = 1'b0;
    logic       cd_n_i = 1'b1;
    logic [7:0] cpu_rdata_o, tx_data_o, flags_o;
    logic       tx_valid_o, rx_overrun_o;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_buf_status #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .uart_en_i(uart_en_i),
        .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rd_i(cpu_rd_i),
        .cpu_rdata_o(cpu_rdata_o), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
        .tx_pop_i(tx_pop_i), .tx_shifting_i(tx_shifting_i), .rx_push_i(rx_push_i),
        .rx_data_i(rx_data_i), .cd_n_i(cd_n_i), .flags_o(flags_o),
        .rx_overrun_o(rx_overrun_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change at the falling edge only.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_tx(input logic [7:0] d);
        cpu_wr_i = 1'b1; cpu_wdata_i = d; step(); cpu_wr_i = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push_i = 1'b1; rx_data_i = d; step(); rx_push_i = 1'b0;
    endtask

    // Check the presented byte, then read it.
    task automatic rd_rx(input string req, input logic [7:0] exp);
        cpu_rd_i = 1'b1; #1;
        check(req, cpu_rdata_o, exp);
        @(negedge clk); cpu_rd_i = 1'b0;
    endtask

    task automatic pop_tx(input string req, input logic [7:0] exp);
        check(req, tx_data_o, exp);
        tx_pop_i = 1'b1; step(); tx_pop_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flags", flags_o, 8'h90);
        check("R1 overrun", {7'd0, rx_overrun_o}, 8'h00);
        check("R1 tx_valid", {7'd0, tx_valid_o}, 8'h00);
        check("R12 low bits", {6'd0, flags_o[1:0]}, 8'h00);
    endtask

    task automatic t_carrier();
        cd_n_i = 1'b0; step();
        check("R2 one edge", {7'd0, flags_o[2]}, 8'h00);
        step();
        check("R2 two edges", {7'd0, flags_o[2]}, 8'h01);
        cd_n_i = 1'b1; step(); step();
        check("R2 release", {7'd0, flags_o[2]}, 8'h00);
    endtask

    task automatic t_holding_tx();
        wr_tx(8'hA5);
        check("R3 busy disabled", {7'd0, flags_o[3]}, 8'h01);
        check("R5 full/empty", {flags_o[7], flags_o[5]} , 8'h01);
        check("R11 valid gated", {7'd0, tx_valid_o}, 8'h00);
        wr_tx(8'h3C);
        uart_en_i = 1'b1; #0;
        check("R11 valid", {7'd0, tx_valid_o}, 8'h01);
        check("R5 data kept", tx_data_o, 8'hA5);
        tx_shifting_i = 1'b1;
        pop_tx("R5 head", 8'hA5);
        check("R5 second write ignored", {7'd0, flags_o[7]}, 8'h01);
        check("R4 busy while shifting", {7'd0, flags_o[3]}, 8'h01);
        tx_shifting_i = 1'b0; #1;
        check("R4 busy released", flags_o, 8'h90);
    endtask

    task automatic t_fifo_tx();
        fifo_en_i = 1'b1; step();
        for (int i = 0; i < DEPTH - 1; i++) wr_tx(8'h10 + 8'(i));
        check("R6 not full", {7'd0, flags_o[5]}, 8'h00);
        wr_tx(8'h10 + 8'(DEPTH - 1));
        check("R6 full", {7'd0, flags_o[5]}, 8'h01);
        wr_tx(8'h99);
        for (int i = 0; i < DEPTH; i++) pop_tx("R6 order", 8'h10 + 8'(i));
        check("R6 extra write ignored", flags_o, 8'h90);
    endtask

    task automatic t_fifo_rx();
        for (int i = 0; i < DEPTH; i++) push_rx(8'h40 + 8'(i));
        check("R7 rx full", {flags_o[6], flags_o[4]}, 8'h02);
        push_rx(8'hEE);
        check("R8 overrun", {7'd0, rx_overrun_o}, 8'h01);
        for (int i = 0; i < DEPTH; i++) rd_rx("R7 order", 8'h40 + 8'(i));
        check("R8 dropped", {7'd0, flags_o[4]}, 8'h01);
        rd_rx("R9 empty read", 8'h00);
        check("R9 still empty", flags_o, 8'h90);
        check("R8 sticky", {7'd0, rx_overrun_o}, 8'h01);
    endtask

    task automatic t_flush();
        uart_en_i = 1'b0;
        push_rx(8'h55); push_rx(8'h66);
        wr_tx(8'h77); wr_tx(8'h88);
        check("R10 filled", {flags_o[7], flags_o[4]}, 8'h00);
        fifo_en_i = 1'b0; step();
        check("R10 flushed", flags_o, 8'h90);
        push_rx(8'h21);
        check("R7 holding full", {flags_o[6], flags_o[4]}, 8'h02);
        push_rx(8'h22);
        rd_rx("R7 holding data", 8'h21);
        check("R7 holding empty", {7'd0, flags_o[4]}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_carrier();
        t_holding_tx();
        t_fifo_tx();
        t_fifo_rx();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule